// File: doc/BRIEF.md
# Multicarrier Sine-Triangle PWM Generator

This block drives the four switching cells of one leg of a multilevel inverter. It holds a sampled digital sine reference and compares it with four digital triangular carriers. Each comparison gives one firing signal. The number of firing signals that are high is the voltage level the leg should apply, from 0 to 4. The reference is built on chip from a quarter-wave sine table and is scaled by an 8-bit depth input. A third-harmonic component can be added to the reference when flat-topping is wanted.

A 3-bit arrangement input selects how the carriers sit relative to each other and to the reference. In the three band arrangements each carrier owns one quarter of the range. These differ only in which carriers are inverted. In the shifted arrangement every carrier spans the whole range, with the phases spread evenly. In the hybrid arrangement there are two shifted pairs, one in each half of the range. A 2-bit step input rotates all carriers in quarter-period steps against the reference. The carrier-to-reference frequency ratio is a parameter (`MF`, default 15). It should be a multiple of three.

Top module: `mcpwm_gen`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `fire` and `level` are 0. The held reference resets to the mid code 128. With `depth` = 0 the first registered outputs after reset are therefore `fire` = 4'b0011 and `level` = 2.
- R2: A free-running count m runs from 0 to 512*MF-1 and then wraps. The carrier phase is ph = (m + 256 - 128*MF + 128*`step`) mod 512, with the first term taken mod 512. The triangle value is ph for ph < 256 and 511-ph otherwise. The reference is resampled only when ph is 0 (trough) or 256 (peak). With `step` = 0, the sample taken at the reference crest is a carrier peak. With `step` = 2, that sample is a trough.
- R3: The reference at count m uses the angle index a = floor(m/(8*MF)), in 0..63. The sine term is 127*sin(2*pi*(a+0.5)/64), read from a 16-entry quarter-wave table of rounded values. The held code is 128 + floor(v*`depth`/256), where v is the signed sine term. The code is offset binary.
- R4: When `third_en` is 1, floor(77*s3/256) is added to v. Here s3 is the same table read at index (3*a) mod 64, which gives a third harmonic of about 30 %.
- R5: `mode` = 0 is phase disposition: carrier i = 64*i + tri/4.
- R6: `mode` = 1 is phase opposition disposition. Carriers 0 and 1 are inverted, carrier i = 64*i + 63 - tri/4. Carriers 2 and 3 are as in R5.
- R7: `mode` = 2 is alternate phase opposition. The odd carriers are inverted as in R6 and the even carriers are as in R5.
- R8: `mode` = 3 is phase shifted. Carrier i is the triangle value of (ph + 128*i) mod 512 and spans the full range.
- R9: `mode` = 4 is hybrid phase shifted. Carrier i = 128*(i/2) + tri((ph + 256*(i mod 2)) mod 512)/2.
- R10: Bit `fire`[i] is high when the held reference is strictly greater than carrier i. `level` is the number of high bits in `fire`. Both are registered, so they change one clock after the count and the reference they come from.
- R11: `mode` codes 5, 6 and 7 behave exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| depth | input | 8 | Modulation depth, 0..255 as a fraction of 256 |
| mode | input | 3 | Carrier arrangement code |
| third_en | input | 1 | Add third-harmonic component to the reference |
| step | input | 2 | Carrier rotation in quarter-period steps |
| fire | output | 4 | Firing signal for each cell, bit i from carrier i |
| level | output | 3 | Count of high firing signals, 0..4 |

## Verification
The hardest case to reach from the ports is the reference moving between samples. A reference sample taken one half-period early or late, or taken at the wrong carrier extremum for a given step, only shows up as a firing edge that moves by a few hundred cycles within one reference period. To catch this, the bench runs a model in step with the clock. The model uses the real-valued sine and the same phase arithmetic as the requirements. It compares every cycle of a full reference period where the reference is at least four codes from every carrier. This is done for each arrangement, for rotated steps and with the harmonic both on and off. Zero depth gives an exactly known mid-code reference, which lets the band layouts and the shifted-carrier duty be checked cycle by cycle with no tolerance.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

    typedef enum logic [2:0] {
        ARR_PD   = 3'd0,
        ARR_POD  = 3'd1,
        ARR_APOD = 3'd2,
        ARR_PS   = 3'd3,
        ARR_HPS  = 3'd4
    } arr_e;

    localparam int PH_W  = 9;
    localparam int CAR_W = 8;

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            smp;
    } phase_s;

    function automatic logic [CAR_W-1:0] tri_of(input logic [PH_W-1:0] p);
        return p[PH_W-1] ? ~p[CAR_W-1:0] : p[CAR_W-1:0];
    endfunction

    function automatic logic [6:0] qsine(input logic [3:0] k);
        logic [6:0] r;
        case (k)
            4'd0:  r = 7'd6;
            4'd1:  r = 7'd19;
            4'd2:  r = 7'd31;
            4'd3:  r = 7'd43;
            4'd4:  r = 7'd54;
            4'd5:  r = 7'd65;
            4'd6:  r = 7'd76;
            4'd7:  r = 7'd85;
            4'd8:  r = 7'd94;
            4'd9:  r = 7'd102;
            4'd10: r = 7'd109;
            4'd11: r = 7'd115;
            4'd12: r = 7'd120;
            4'd13: r = 7'd123;
            4'd14: r = 7'd126;
            default: r = 7'd127;
        endcase
        return r;
    endfunction

    function automatic logic signed [17:0] wave(input logic [5:0] a);
        logic [3:0] idx;
        logic signed [17:0] mag;
        idx = a[4] ? ~a[3:0] : a[3:0];
        mag = $signed({11'd0, qsine(idx)});
        return a[5] ? -mag : mag;
    endfunction

endpackage

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase
    import mcpwm_pkg::*;
#(
    parameter int MF = 15,
    localparam int PERIOD = 512 * MF,
    localparam int MW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    step,
    output logic [MW-1:0] m,
    output phase_s        phs
);
    localparam int ALIGN = (256 - (128 * MF) % 512 + 512) % 512;

    always_ff @(posedge clk) begin
        if (rst)
            m <= '0;
        else if (m == MW'(PERIOD - 1))
            m <= '0;
        else
            m <= m + 1'b1;
    end

    always_comb begin
        phs.ph  = m[PH_W-1:0] + PH_W'(ALIGN) + {step, 7'd0};
        phs.smp = (phs.ph == 9'd0) || (phs.ph == 9'd256);
    end

endmodule

// File: rtl/mcpwm_reference.sv
module mcpwm_reference
    import mcpwm_pkg::*;
#(
    parameter int MF = 15,
    parameter int MW = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MW-1:0]    m,
    input  logic             smp,
    input  logic [7:0]       depth,
    input  logic             third_en,
    output logic [CAR_W-1:0] ref_q
);
    localparam int DIV = 8 * MF;

    logic [5:0]         ang;
    logic [5:0]         ang3;
    logic signed [17:0] s1, s3, hp, v, sp, r;
    logic [CAR_W-1:0]   ref_n;

    always_comb begin
        ang  = 6'(m / MW'(DIV));
        ang3 = ang * 6'd3;
        s1   = wave(ang);
        s3   = wave(ang3);
        hp   = s3 * 18'sd77;
        v    = s1 + (third_en ? (hp >>> 8) : 18'sd0);
        sp   = v * $signed({10'd0, depth});
        r    = 18'sd128 + (sp >>> 8);
        if (r < 18'sd0)
            ref_n = '0;
        else if (r > 18'sd255)
            ref_n = '1;
        else
            ref_n = r[CAR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ref_q <= 8'd128;
        else if (smp)
            ref_q <= ref_n;
    end

endmodule

// File: rtl/mcpwm_carriers.sv
module mcpwm_carriers
    import mcpwm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [2:0]                  mode,
    input  logic [PH_W-1:0]             ph,
    output logic [N-1:0][CAR_W-1:0]     car
);
    localparam int BAND     = 256 / N;
    localparam int BSH      = $clog2(N);
    localparam int HALF     = N / 2;
    localparam int PS_STEP  = 512 / N;
    localparam int HPS_STEP = 512 / HALF;

    for (genvar gi = 0; gi < N; gi++) begin : g_car
        localparam logic [PH_W-1:0]  PSO  = PH_W'((PS_STEP * gi) % 512);
        localparam logic [PH_W-1:0]  HSO  = PH_W'((HPS_STEP * (gi % HALF)) % 512);
        localparam logic [CAR_W-1:0] BOFF = CAR_W'(BAND * gi);
        localparam logic [CAR_W-1:0] GOFF = CAR_W'(128 * (gi / HALF));
        localparam bit INV_LO  = (gi < HALF);
        localparam bit INV_ODD = ((gi % 2) == 1);

        logic [CAR_W-1:0] ramp, up, dn;

        always_comb begin
            ramp = tri_of(ph) >> BSH;
            up   = BOFF + ramp;
            dn   = BOFF + (CAR_W'(BAND - 1) - ramp);
            case (mode)
                ARR_POD:  car[gi] = INV_LO ? dn : up;
                ARR_APOD: car[gi] = INV_ODD ? dn : up;
                ARR_PS:   car[gi] = tri_of(ph + PSO);
                ARR_HPS:  car[gi] = GOFF + (tri_of(ph + HSO) >> 1);
                default:  car[gi] = up;
            endcase
        end
    end

endmodule

// File: rtl/mcpwm_gen.sv
module mcpwm_gen
    import mcpwm_pkg::*;
#(
    parameter int N  = 4,
    parameter int MF = 15,
    localparam int LW = $clog2(N + 1),
    localparam int MW = $clog2(512 * MF)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    depth,
    input  logic [2:0]    mode,
    input  logic          third_en,
    input  logic [1:0]    step,
    output logic [N-1:0]  fire,
    output logic [LW-1:0] level
);
    logic [MW-1:0]              m;
    phase_s                     phs;
    logic [CAR_W-1:0]           ref_q;
    logic [N-1:0][CAR_W-1:0]    car;
    logic [N-1:0]               fire_d;
    logic [LW-1:0]              lvl_d;

    mcpwm_timebase #(.MF(MF)) u_tb (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .m    (m),
        .phs  (phs)
    );

    mcpwm_reference #(.MF(MF), .MW(MW)) u_ref (
        .clk      (clk),
        .rst      (rst),
        .m        (m),
        .smp      (phs.smp),
        .depth    (depth),
        .third_en (third_en),
        .ref_q    (ref_q)
    );

    mcpwm_carriers #(.N(N)) u_car (
        .mode (mode),
        .ph   (phs.ph),
        .car  (car)
    );

    always_comb begin
        lvl_d = '0;
        for (int i = 0; i < N; i++) begin
            fire_d[i] = ref_q > car[i];
            lvl_d     = lvl_d + LW'(fire_d[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fire  <= '0;
            level <= '0;
        end else begin
            fire  <= fire_d;
            level <= lvl_d;
        end
    end

endmodule

// File: rtl/mcpwm_gen_chk.sv
module mcpwm_gen_chk #(
    parameter int N = 4,
    localparam int LW = $clog2(N + 1),
    localparam int HALF = N / 2
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    mode,
    input logic [N-1:0]  fire,
    input logic [LW-1:0] level
);
    // R1: reset clears the registered outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (fire == '0 && level == '0));

    // R5 R6 R7 R11: band arrangements always give a thermometer pattern
    assert_band_thermo_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) != 3'd3 && $past(mode) != 3'd4)
        |-> ((fire & (fire + 1'b1)) == '0));

    // R9: the upper pair can only fire when both lower carriers fire
    assert_hybrid_groups_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == 3'd4 && (|fire[N-1:HALF]))
        |-> (&fire[HALF-1:0]));

    // R10: level never exceeds the cell count
    assert_level_range_R10: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(N));

endmodule

bind mcpwm_gen mcpwm_gen_chk #(.N(N)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .fire  (fire),
    .level (level)
);

// File: tb/mcpwm_gen_test.sv
module mcpwm_gen_test;
    localparam int N  = 4;
    localparam int MF = 15;
    localparam int PERIOD = 512 * MF;
    localparam int ALIGN = (256 - (128 * MF) % 512 + 512) % 512;
    localparam real TWO_PI = 6.283185307179586;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] depth = 8'd0;
    logic [2:0] mode = 3'd0;
    logic       third_en = 1'b0;
    logic [1:0] step = 2'd0;
    logic [N-1:0] fire;
    logic [2:0]   level;

    int nchk = 0;
    int nfail = 0;

    mcpwm_gen #(.N(N), .MF(MF)) uut (
        .clk(clk), .rst(rst), .depth(depth), .mode(mode),
        .third_en(third_en), .step(step), .fire(fire), .level(level)
    );

    always #4 clk = ~clk;

    // ---------------- requirement model ----------------
    function automatic int tri_f(input int p);
        int q;
        q = p % 512;
        return (q < 256) ? q : 511 - q;
    endfunction

    function automatic int car_f(input int md, input int i, input int ph);
        int t, up, dn;
        t  = tri_f(ph);
        up = 64 * i + t / 4;
        dn = 64 * i + 63 - t / 4;
        case (md)
            1: return (i < 2) ? dn : up;
            2: return (i % 2 == 1) ? dn : up;
            3: return tri_f(ph + 128 * i);
            4: return 128 * (i / 2) + tri_f(ph + 256 * (i % 2)) / 2;
            default: return up;
        endcase
    endfunction

    function automatic real ref_f(input int mm, input int dep, input bit inj);
        int a, a3;
        real v;
        a  = mm / (8 * MF);
        a3 = (3 * a) % 64;
        v  = 127.0 * $sin(TWO_PI * (a + 0.5) / 64.0);
        if (inj) v = v + 0.30078125 * 127.0 * $sin(TWO_PI * (a3 + 0.5) / 64.0);
        return 128.0 + v * dep / 256.0;
    endfunction

    int        bm;
    real       bref;
    logic [N-1:0] efire;
    bit        ev;
    int        mph, mc;
    real       md_diff;
    logic [N-1:0] mf_bits;
    bit        mok;

    always @(posedge clk) begin
        if (rst) begin
            bm    <= 0;
            bref  <= 128.0;
            efire <= '0;
            ev    <= 1'b0;
        end else begin
            mph = (bm + ALIGN + 128 * int'(step)) % 512;
            mok = 1'b1;
            for (int i = 0; i < N; i++) begin
                mc = car_f(int'(mode), i, mph);
                md_diff = bref - mc;
                mf_bits[i] = md_diff > 0.0;
                if (bref != 128.0 && md_diff < 4.0 && md_diff > -4.0) mok = 1'b0;
            end
            efire <= mf_bits;
            ev    <= mok;
            if (mph == 0 || mph == 256) bref <= ref_f(bm, int'(depth), third_en);
            bm <= (bm == PERIOD - 1) ? 0 : bm + 1;
        end
    end

    // ---------------- reporting ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic setup(input int md, input int st, input bit inj, input int dep);
        @(negedge clk);
        mode = 3'(md);
        step = 2'(st);
        third_en = inj;
        depth = 8'(dep);
    endtask

    // R1: reset state and first cycle after reset
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(fire == 4'b0000, "R1 fire during reset", int'(fire), 0);
        check(level == 3'd0, "R1 level during reset", int'(level), 0);
        rst = 1'b0;
        @(negedge clk);
        check(fire == 4'b0011, "R1 mid reference after reset", int'(fire), 3);
        check(level == 3'd2, "R1 level after reset", int'(level), 2);
    endtask

    // R5 R6 R7 R9: zero depth, band layouts put exactly the lower two carriers below 128
    task automatic t_flat_band(input int md, input string tag);
        int bad;
        setup(md, 0, 1'b0, 0);
        repeat (520) @(negedge clk);
        bad = 0;
        for (int k = 0; k < 512; k++) begin
            @(negedge clk);
            if (fire != 4'b0011 || level != 3'd2) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    // R8: zero depth in shifted mode, each carrier half duty, staggered edges
    task automatic t_flat_ps();
        int hi [N];
        int chg, badlvl;
        logic [N-1:0] prev;
        setup(3, 0, 1'b0, 0);
        repeat (520) @(negedge clk);
        for (int i = 0; i < N; i++) hi[i] = 0;
        chg = 0;
        badlvl = 0;
        prev = fire;
        for (int k = 0; k < 1024; k++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) if (fire[i]) hi[i]++;
            if (fire != prev) chg++;
            if (level != 3'd2) badlvl++;
            prev = fire;
        end
        for (int i = 0; i < N; i++) check(hi[i] == 512, "R8 shifted carrier duty", hi[i], 512);
        check(chg == 8, "R8 shifted change events per two periods", chg, 8);
        check(badlvl == 0, "R8 shifted level at mid reference", badlvl, 0);
    endtask

    // R2-R11: one full reference period against the model
    task automatic t_sine(input string tag, input int md, input int st, input bit inj, input int dep);
        int cmp, mis, lvlbad;
        logic [N-1:0] first_act, first_exp;
        bit seen;
        setup(md, st, inj, dep);
        cmp = 0; mis = 0; lvlbad = 0; seen = 1'b0;
        first_act = '0; first_exp = '0;
        for (int k = 0; k < PERIOD; k++) begin
            @(negedge clk);
            if (ev) begin
                cmp++;
                if (fire != efire) begin
                    mis++;
                    if (!seen) begin
                        seen = 1'b1;
                        first_act = fire;
                        first_exp = efire;
                    end
                end
            end
            if (int'(level) != $countones(fire)) lvlbad++;
        end
        check(mis == 0, tag, int'(first_act), int'(first_exp));
        check(cmp > 1000, {tag, " coverage"}, cmp, 1001);
        check(lvlbad == 0, {tag, " R10 level count"}, lvlbad, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        #(8 * 200000);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_flat_band(0, "R5 band layout at mid reference");
        t_flat_band(1, "R6 band layout at mid reference");
        t_flat_band(2, "R7 band layout at mid reference");
        t_flat_band(4, "R9 hybrid layout at mid reference");
        t_flat_ps();
        t_sine("R5 disposition sine", 0, 0, 1'b0, 230);
        t_sine("R6 opposition sine", 1, 0, 1'b0, 230);
        t_sine("R7 alternate opposition sine", 2, 0, 1'b0, 230);
        t_sine("R8 shifted sine", 3, 0, 1'b0, 230);
        t_sine("R9 hybrid sine", 4, 0, 1'b0, 230);
        t_sine("R2 half-turn step with R4 harmonic", 0, 2, 1'b1, 250);
        t_sine("R4 harmonic shifted quarter step", 3, 1, 1'b1, 255);
        t_sine("R3 reduced depth three-quarter step", 2, 3, 1'b0, 128);
        t_sine("R11 unused code acts as disposition", 6, 1, 1'b1, 200);
        summary();
        $finish;
    end

endmodule